// File: doc/BRIEF.md
# Flash Command State Machine

This block is a device-side model of the command interface of a parallel NOR flash in 16-bit word mode. It watches chip-enable, write-enable and output-enable strobes (all active low) together with the address and data buses. It decodes multi-cycle unlock command sequences from the bus write cycles, and it answers read cycles. A read returns array contents, identifier codes, or a busy-status word, depending on the command state. The storage is a small internal word array split into equal sectors. Each sector has a protection bit that is fixed at build time by a parameter.

A host reads the array with plain read cycles and needs no command first. To program a word, the host writes two unlock cycles, the program setup code, and then the target address with its data. To enter identifier mode it writes the two unlocks and the identifier code. To clear the whole array it writes six cycles. Programming can only clear bits. While an internal program or erase runs, all writes are ignored and reads return a status word. On a program, bit 7 of that word stays inverted until the program completes.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, every array word holds all ones, the block is in read mode, and `dout` is zero.
- R2: When `ce_n` and `oe_n` are both low at a clock edge, `dout` shows the selected word after that edge. In read mode this is the array word at `addr[ARR_AW-1:0]`. When the two strobes are not both low, `dout` is zero after the edge.
- R3: The address of a write cycle is captured at the first clock edge where `ce_n` and `we_n` are both low. The data is taken from `din` at the first edge where they are no longer both low, and the command acts at that same edge.
- R4: The sequence AAh@555h, 55h@2AAh, 90h@555h enters identifier mode. Unlock addresses are compared on `addr[10:0]`; codes are compared on `din[7:0]`. In identifier mode, reads are selected by `addr[1:0]`: 0 gives `MFR_ID`, 1 gives `DEV_ID`, 2 gives the protection bit on bit 0 of the sector selected by `addr[ARR_AW-1 -: SECT_W]`, and 3 gives zero.
- R5: The sequence AAh@555h, 55h@2AAh, A0h@555h, followed by one write of address and data, programs that word. The stored result is the old word ANDed with the data, so a bit that is 0 stays 0.
- R6: A program keeps the block busy for exactly `PROG_CYC` read results, counted from the edge after the data write ends. During that time every read returns a word with bit 7 equal to the inverse of the written bit 7 and all other bits zero. The next read returns the stored word.
- R7: Every write cycle that ends while a program or erase is running is ignored, including unlock and reset codes.
- R8: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h erases the array. For `ERASE_CYC` cycles, reads return zero. Afterwards every unprotected word reads all ones.
- R9: Words in a sector whose `PROT_INIT` bit is set never change, whether by program or by erase.
- R10: Identifier mode is left only by a write of F0h to any address. Any other write in identifier mode is ignored.
- R11: A write that does not match the next step of a sequence returns the block to read mode. F0h at any step before the program data write also returns it to read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address bus |
| din | input | DATA_W | Write data bus |
| dout | output | DATA_W | Registered read data, zero when not reading |

## Verification
Read data is registered, so a value is due one clock edge after the edge that first sees `ce_n` and `oe_n` both low. The bench raises the read strobes on a falling edge and samples `dout` on the next falling edge. A write takes effect at the edge where the strobes rise. The status window of a program therefore covers the `PROG_CYC` samples that follow the first sample after that edge, and the bench checks each of those samples by number. The check after it expects the stored word. Erase and bulk programming are given their full cycle budget plus margin before the array is swept word by word against a model held in the bench.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_AUTO,
    ST_PSET,
    ST_ES1,
    ST_ES2,
    ST_ES3,
    ST_BPROG,
    ST_BERASE
  } fcsm_state_e;

  localparam logic [10:0] UNL_A1 = 11'h555;
  localparam logic [10:0] UNL_A2 = 11'h2AA;

  localparam logic [7:0] K_UNL1 = 8'hAA;
  localparam logic [7:0] K_UNL2 = 8'h55;
  localparam logic [7:0] K_PROG = 8'hA0;
  localparam logic [7:0] K_AUTO = 8'h90;
  localparam logic [7:0] K_RST  = 8'hF0;
  localparam logic [7:0] K_ESET = 8'h80;
  localparam logic [7:0] K_CHIP = 8'h10;

endpackage

// File: rtl/fcsm_strobe.sv
module fcsm_strobe #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_end,
  output logic [ADDR_W-1:0] waddr
);

  logic wr_act;
  logic wr_act_q;

  assign wr_act = ~ce_n & ~we_n;
  assign wr_end = wr_act_q & ~wr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      waddr    <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act && !wr_act_q) waddr <= addr;
    end
  end

  // R3: the captured address holds for as long as the write stays active
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_act_q && wr_act) |=> $stable(waddr));

endmodule

// File: rtl/fcsm_decoder.sv
module fcsm_decoder
  import fcsm_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int ARR_AW    = 6,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_end,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output fcsm_state_e       state,
  output logic [ARR_AW-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              pgm_fire,
  output logic              erase_fire
);

  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       code;
  logic             at_a1;
  logic             at_a2;

  assign code  = wdata[7:0];
  assign at_a1 = (waddr[10:0] == UNL_A1);
  assign at_a2 = (waddr[10:0] == UNL_A2);

  assign pgm_fire   = (state == ST_BPROG)  && (cnt == '0);
  assign erase_fire = (state == ST_BERASE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_READ;
      cnt      <= '0;
      pgm_addr <= '0;
      pgm_data <= '0;
    end else begin
      case (state)
        ST_BPROG, ST_BERASE: begin
          if (cnt == '0) state <= ST_READ;
          else           cnt   <= cnt - 1'b1;
        end
        ST_PSET: begin
          if (wr_end) begin
            pgm_addr <= waddr[ARR_AW-1:0];
            pgm_data <= wdata;
            cnt      <= CNT_W'(PROG_CYC - 1);
            state    <= ST_BPROG;
          end
        end
        ST_AUTO: begin
          if (wr_end && code == K_RST) state <= ST_READ;
        end
        ST_READ: begin
          if (wr_end) state <= (code == K_UNL1 && at_a1) ? ST_UNL1 : ST_READ;
        end
        ST_UNL1: begin
          if (wr_end) state <= (code == K_UNL2 && at_a2) ? ST_UNL2 : ST_READ;
        end
        ST_UNL2: begin
          if (wr_end) begin
            if (at_a1 && code == K_PROG)      state <= ST_PSET;
            else if (at_a1 && code == K_AUTO) state <= ST_AUTO;
            else if (at_a1 && code == K_ESET) state <= ST_ES1;
            else                              state <= ST_READ;
          end
        end
        ST_ES1: begin
          if (wr_end) state <= (code == K_UNL1 && at_a1) ? ST_ES2 : ST_READ;
        end
        ST_ES2: begin
          if (wr_end) state <= (code == K_UNL2 && at_a2) ? ST_ES3 : ST_READ;
        end
        ST_ES3: begin
          if (wr_end) begin
            if (code == K_CHIP && at_a1) begin
              cnt   <= CNT_W'(ERASE_CYC - 1);
              state <= ST_BERASE;
            end else begin
              state <= ST_READ;
            end
          end
        end
        default: state <= ST_READ;
      endcase
    end
  end

  // R7: while a program runs, its target and data are frozen and no command moves the state
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BPROG && cnt != '0) |=>
      (state == ST_BPROG && $stable(pgm_addr) && $stable(pgm_data)));

  // R7: an erase in progress leaves only to read mode
  a_r7_erase_exit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BERASE) |=> (state == ST_BERASE || state == ST_READ));

  // R10: identifier mode survives every write other than the reset code
  a_r10_auto_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AUTO && wr_end && code != K_RST) |=> (state == ST_AUTO));

  // R11: a wrong second unlock write falls back to read mode
  a_r11_bad_unlock: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UNL1 && wr_end && !(code == K_UNL2 && at_a2)) |=> (state == ST_READ));

endmodule

// File: rtl/fcsm_array.sv
module fcsm_array #(
  parameter int DATA_W = 16,
  parameter int ARR_AW = 6,
  parameter int SECT_W = 2,
  parameter logic [(1<<SECT_W)-1:0] PROT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pgm_fire,
  input  logic [ARR_AW-1:0] pgm_addr,
  input  logic [DATA_W-1:0] pgm_data,
  input  logic              erase_fire,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic [(1<<SECT_W)-1:0] prot_bits
);

  localparam int DEPTH = 1 << ARR_AW;
  localparam int SHIFT = ARR_AW - SECT_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem;

  assign prot_bits = PROT_INIT;
  assign rd_word   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!PROT_INIT[i >> SHIFT]) begin
          if (erase_fire)
            mem[i] <= '1;
          else if (pgm_fire && pgm_addr == ARR_AW'(i))
            mem[i] <= mem[i] & pgm_data;
        end
      end
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_chk
    // R5: outside an erase, a stored bit never goes from 0 to 1
    a_r5_only_clear: assert property (@(posedge clk) disable iff (rst)
      !$past(erase_fire) |-> ((mem[gi] & ~$past(mem[gi])) == '0));
    // R9: words of a protected sector hold their value
    if (PROT_INIT[gi >> SHIFT]) begin : g_lock
      a_r9_locked_stable: assert property (@(posedge clk) disable iff (rst)
        $stable(mem[gi]));
    end
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcsm_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int ARR_AW    = 6,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter logic [(1<<SECT_W)-1:0] PROT_INIT = 4'b0100,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h0004,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h223B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int SECTORS = 1 << SECT_W;

  logic              wr_end;
  logic [ADDR_W-1:0] waddr;
  fcsm_state_e       state;
  logic [ARR_AW-1:0] pgm_addr;
  logic [DATA_W-1:0] pgm_data;
  logic              pgm_fire;
  logic              erase_fire;
  logic [DATA_W-1:0] rd_word;
  logic [SECTORS-1:0] prot_bits;
  logic              rd_act;
  logic [DATA_W-1:0] rd_next;
  logic [SECT_W-1:0] rd_sec;

  fcsm_strobe #(.ADDR_W(ADDR_W)) strobe_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .wr_end(wr_end), .waddr(waddr)
  );

  fcsm_decoder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) decoder_i (
    .clk(clk), .rst(rst), .wr_end(wr_end), .waddr(waddr), .wdata(din),
    .state(state), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .pgm_fire(pgm_fire), .erase_fire(erase_fire)
  );

  fcsm_array #(
    .DATA_W(DATA_W), .ARR_AW(ARR_AW), .SECT_W(SECT_W), .PROT_INIT(PROT_INIT)
  ) array_i (
    .clk(clk), .rst(rst), .pgm_fire(pgm_fire), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .erase_fire(erase_fire),
    .rd_addr(addr[ARR_AW-1:0]), .rd_word(rd_word), .prot_bits(prot_bits)
  );

  assign rd_act = ~ce_n & ~oe_n;
  assign rd_sec = addr[ARR_AW-1 -: SECT_W];

  always_comb begin
    rd_next = '0;
    case (state)
      ST_BPROG:  rd_next[7] = ~pgm_data[7];
      ST_BERASE: rd_next    = '0;
      ST_AUTO: begin
        case (addr[1:0])
          2'd0:    rd_next = MFR_ID;
          2'd1:    rd_next = DEV_ID;
          2'd2:    rd_next[0] = prot_bits[rd_sec];
          default: rd_next = '0;
        endcase
      end
      default:   rd_next = rd_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (rd_act) dout <= rd_next;
    else             dout <= '0;
  end

  // R2: the output bus is idle one edge after a cycle without an active read
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> (dout == '0));

  // R6: while a program is busy, only bit 7 of a read result may be set
  a_r6_status_shape: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BPROG) |=> ((dout & ~(DATA_W'(1) << 7)) == '0));

endmodule

// File: tb/flash_cmd_fsm_tb.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb_top;

  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 40;
  localparam int DEPTH     = 64;
  localparam logic [3:0]  PROT = 4'b0100;
  localparam logic [15:0] MFR  = 16'h0004;
  localparam logic [15:0] DEV  = 16'h223B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;

  int checks = 0;
  int failures = 0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  flash_cmd_fsm #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_INIT(PROT),
    .MFR_ID(MFR), .DEV_ID(DEV)
  ) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit locked(input int a);
    return PROT[(a >> 4) & 3];
  endfunction

  function automatic logic [15:0] pat(input int i, input int salt);
    return 16'((i * 40503 + salt * 977) ^ 16'hA5C3);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic brd(input logic [10:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    bwr(11'h555, 16'h00AA);
    bwr(11'h2AA, 16'h0055);
  endtask

  task automatic prog(input int a, input logic [15:0] d);
    unlock();
    bwr(11'h555, 16'h00A0);
    bwr(11'(a), d);
    idle(PROG_CYC + 2);
    if (!locked(a)) model[a] = model[a] & d;
  endtask

  // Program word a and check every read result of the status window by number.
  task automatic prog_watch(input int a, input logic [15:0] d, input string req);
    logic [15:0] st;
    st = '0;
    st[7] = ~d[7];
    unlock();
    bwr(11'h555, 16'h00A0);
    bwr(11'(a), d);
    addr = 11'(a); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    for (int k = 1; k <= PROG_CYC; k++) begin
      @(negedge clk);
      chk(req, dout, st);
    end
    if (!locked(a)) model[a] = model[a] & d;
    @(negedge clk);
    chk(req, dout, model[a]);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(2);
  endtask

  task automatic sweep(input string req);
    logic [15:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      brd(11'(i), v);
      chk(req, v, model[i]);
    end
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset dout", dout, 16'h0000);

    // R1 R2: whole array reads erased after reset
    sweep("R1 R2 reset array");
    @(negedge clk);
    chk("R2 idle after read", dout, 16'h0000);

    // R4: identifier mode
    unlock();
    bwr(11'h555, 16'h0090);
    brd(11'h000, v); chk("R4 manufacturer", v, MFR);
    brd(11'h7C1, v); chk("R4 device id upper addr bits ignored", v, DEV);
    brd(11'h003, v); chk("R4 offset 3", v, 16'h0000);
    for (int s = 0; s < 4; s++) begin
      brd(11'((s << 4) | 2), v);
      chk("R4 sector protection", v, {15'h0, PROT[s]});
    end
    // R10: other writes keep identifier mode
    bwr(11'h555, 16'h00AA);
    bwr(11'h013, 16'h0000);
    brd(11'h000, v); chk("R10 stays in identifier mode", v, MFR);
    bwr(11'h123, 16'h00F0);
    brd(11'h000, v); chk("R10 reset leaves identifier mode", v, model[0]);

    // R5 R6 R3: exact busy window on a few words
    prog_watch(5, 16'h1234, "R6 R3 status bit7 low data");
    prog_watch(6, 16'hBEEF, "R6 status bit7 high data");
    // R5: bit 7 already 0, asked to become 1: status never matches, value stays 0
    prog_watch(5, 16'hFFFF, "R5 R6 zero cannot rise");

    // R5 R9: program every word, then every word again with a second pattern
    for (int i = 0; i < DEPTH; i++) prog(i, pat(i, 1));
    sweep("R5 R9 first pattern");
    for (int i = 0; i < DEPTH; i += 3) prog(i, pat(i, 2));
    sweep("R5 AND of two patterns");

    // R7: unlock writes during a program are ignored
    unlock();
    bwr(11'h555, 16'h00A0);
    bwr(11'd9, 16'h0F0F);
    bwr(11'h555, 16'h00AA);
    bwr(11'h2AA, 16'h0055);
    idle(PROG_CYC);
    model[9] = model[9] & 16'h0F0F;
    bwr(11'h555, 16'h0090);
    brd(11'h000, v); chk("R7 unlocks in busy ignored", v, model[0]);
    brd(11'd9, v);   chk("R7 program target kept", v, model[9]);

    // R11: broken sequences program nothing
    bwr(11'h555, 16'h00AA);
    bwr(11'h2AA, 16'h0012);
    bwr(11'h555, 16'h00A0);
    bwr(11'd10, 16'h0000);
    idle(PROG_CYC + 2);
    brd(11'd10, v); chk("R11 wrong unlock data", v, model[10]);
    unlock();
    bwr(11'h0AB, 16'h00F0);
    bwr(11'h555, 16'h0090);
    brd(11'h000, v); chk("R11 reset mid sequence", v, model[0]);
    unlock();
    bwr(11'h556, 16'h00A0);
    bwr(11'd11, 16'h0000);
    idle(PROG_CYC + 2);
    brd(11'd11, v); chk("R11 wrong setup address", v, model[11]);

    // R8 R9: chip erase
    unlock();
    bwr(11'h555, 16'h0080);
    unlock();
    bwr(11'h555, 16'h0010);
    brd(11'd3, v); chk("R8 erase busy reads zero", v, 16'h0000);
    bwr(11'h555, 16'h00F0);
    idle(ERASE_CYC);
    for (int i = 0; i < DEPTH; i++) if (!locked(i)) model[i] = 16'hFFFF;
    sweep("R8 R9 after erase");

    // R9: protected sector still refuses a program after erase
    prog(33, 16'h0000);
    brd(11'd33, v); chk("R9 protected word", v, 16'hFFFF);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule